// File: doc/BRIEF.md
# Serial Control Port Volume Attenuator

This block scales a stereo stream of 16-bit signed audio samples by a gain that a microcontroller sets over a three-wire serial port. The port has a control clock, a data line and an active-low load strobe. A command is 14 bits long and is shifted in least significant bit first. The first eight bits carry a device identifier and the last six carry an attenuation code.

When the load strobe falls, the block compares the identifier in the command with its `dev_id` pins. If they match, it stages the code. The port pins are asynchronous to the master clock, so each one passes through a synchronizer before it is used. The control clock idles high.

A one-cycle `sample_strobe` marks each stereo frame. On that cycle both channels are multiplied by the same unsigned 16-bit gain, which the staged code selects. The products are rounded and saturated, and the results are held on the outputs until the next frame.

The gain curve is nonuniform in dB. It steps from 0 dB down to about -36 dB, and the top code silences the output completely.

Top module: `serial_vol_atten`

## Requirements
- R1: A command is 14 bits, sent LSB first: each rising control clock edge, seen while the load strobe is high, shifts in one data bit. Command bits 7..0 (the first eight sent) are the identifier, and bits 13..8 are the attenuation code.
- R2: On the falling edge of the load strobe, a command whose identifier differs from `dev_id` is discarded, and the gain in use stays unchanged.
- R3: Rising control clock edges that arrive while the load strobe is low do not alter the shift register.
- R4: After reset the attenuation code is 0 (0 dB, gain 0xFFFF) and both outputs are 0. A reset asserted after an earlier command returns the gain to 0 dB.
- R5: The gain for code 0 is 0xFFFF. For codes k = 1..63 the gain is (63 - k) * 1024, so code 1 ≈ -0.28 dB, 31 = -6.02 dB, 47 = -12.04 dB, 62 ≈ -36.12 dB, and code 63 gives an output of exactly 0.
- R6: Each output equals floor((x * g + 32768) / 65536), where x is the signed input sample and g is the unsigned gain. The result is clamped to the range -32768..32767. For example, -32768 at code 0 gives -32767.
- R7: The outputs change only on the clock edge that follows a cycle with `sample_strobe` high. An accepted command takes effect on the next such frame.
- R8: Both channels of one frame are scaled by the same gain, so equal left and right inputs give equal outputs.
- R9: When more than 14 bits are clocked in before the load strobe falls, only the last 14 bits count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk | input | 1 | Serial control clock, idles high, asynchronous |
| ctl_data | input | 1 | Serial control data, LSB first |
| ctl_load_n | input | 1 | Active-low load strobe |
| dev_id | input | 8 | Identifier this block answers to |
| sample_strobe | input | 1 | One-cycle pulse marking a stereo frame |
| left_in | input | 16 | Left sample, signed |
| right_in | input | 16 | Right sample, signed |
| left_out | output | 16 | Scaled left sample, signed |
| right_out | output | 16 | Scaled right sample, signed |

## Verification
A wrong shift-register or staged-code state never appears directly at the ports. It shows up as a wrongly scaled sample on the first frame strobe after the load strobe falls, which is one frame late at most. Each command in the bench is therefore followed at once by a frame whose expected value is computed from the gain curve and the rounding rule. Rejected identifiers, surplus bits and clock edges sent while the strobe is low are each followed by such a frame. Outputs are also sampled between frames, so that a register loading outside its strobe shows up on the next cycle.

// File: rtl/vatt_pkg.sv
package vatt_pkg;
  localparam int SAMPLE_W = 16;
  localparam int GAIN_W   = 16;
  localparam int ID_W     = 8;
  localparam int CODE_W   = 6;
  localparam int CMD_W    = ID_W + CODE_W;
  localparam int CHANNELS = 2;
endpackage

// File: rtl/vatt_sync.sv
module vatt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= INIT;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/vatt_cmd_shifter.sv
module vatt_cmd_shifter #(
  parameter int ID_W   = vatt_pkg::ID_W,
  parameter int CODE_W = vatt_pkg::CODE_W,
  localparam int CMD_W = ID_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sld_n_s,
  input  logic [ID_W-1:0]   dev_id,
  output logic [CODE_W-1:0] staged_code
);
  logic             sclk_q, sld_q;
  logic [CMD_W-1:0] shreg;
  logic             sclk_rise, load_fall, id_match, accept;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign load_fall = ~sld_n_s & sld_q;
  assign id_match  = (shreg[ID_W-1:0] == dev_id);
  assign accept    = load_fall & id_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b1;
      sld_q       <= 1'b1;
      shreg       <= '0;
      staged_code <= '0;
    end else begin
      sclk_q <= sclk_s;
      sld_q  <= sld_n_s;
      // LSB arrives first, so new bits enter at the top and move down
      if (sclk_rise && sld_n_s) shreg <= {sdat_s, shreg[CMD_W-1:1]};
      if (accept) staged_code <= shreg[CMD_W-1:ID_W];
    end
  end

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise && sld_n_s) |=> $stable(shreg)); // R3
  AST_CODE_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(staged_code)); // R2
endmodule

// File: rtl/vatt_gain_apply.sv
module vatt_gain_apply #(
  parameter int SAMPLE_W = vatt_pkg::SAMPLE_W,
  parameter int GAIN_W   = vatt_pkg::GAIN_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strobe,
  input  logic [GAIN_W-1:0]          gain,
  input  logic signed [SAMPLE_W-1:0] din,
  output logic signed [SAMPLE_W-1:0] dout
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (GAIN_W - 1);
  localparam logic signed [SAMPLE_W:0] QMAX = {2'b00, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W:0] QMIN = {2'b11, {(SAMPLE_W-1){1'b0}}};

  function automatic logic signed [SAMPLE_W-1:0] scale(
    input logic signed [SAMPLE_W-1:0] x, input logic [GAIN_W-1:0] g);
    logic signed [PW-1:0]     prod;
    logic signed [SAMPLE_W:0] q;
    prod = x * $signed({1'b0, g});
    prod = prod + RND;
    q = prod[PW-1:GAIN_W];
    if (q > QMAX)      scale = QMAX[SAMPLE_W-1:0];
    else if (q < QMIN) scale = QMIN[SAMPLE_W-1:0];
    else               scale = q[SAMPLE_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (strobe) dout <= scale(din, gain);
  end

  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(dout)); // R7
  AST_MUTE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && gain == '0) |=> (dout == '0)); // R5
endmodule

// File: rtl/serial_vol_atten.sv
module serial_vol_atten #(
  parameter int SAMPLE_W    = vatt_pkg::SAMPLE_W,
  parameter int GAIN_W      = vatt_pkg::GAIN_W,
  parameter int ID_W        = vatt_pkg::ID_W,
  parameter int CODE_W      = vatt_pkg::CODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_clk,
  input  logic                       ctl_data,
  input  logic                       ctl_load_n,
  input  logic [ID_W-1:0]            dev_id,
  input  logic                       sample_strobe,
  input  logic signed [SAMPLE_W-1:0] left_in,
  input  logic signed [SAMPLE_W-1:0] right_in,
  output logic signed [SAMPLE_W-1:0] left_out,
  output logic signed [SAMPLE_W-1:0] right_out
);
  localparam int NCH = vatt_pkg::CHANNELS;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  // code 0 is full scale; code k>0 steps down linearly in 1/2^CODE_W units
  function automatic logic [GAIN_W-1:0] gain_of(input logic [CODE_W-1:0] code);
    logic [GAIN_W-1:0] steps;
    if (code == '0) return '1;
    steps = GAIN_W'(CODE_MAX) - GAIN_W'(code);
    return steps << (GAIN_W - CODE_W);
  endfunction

  logic [2:0]        sync_out;
  logic [CODE_W-1:0] staged_code;
  logic [GAIN_W-1:0] frame_gain;
  logic signed [SAMPLE_W-1:0] ch_in  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out [NCH];

  vatt_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ctl_clk, ctl_data, ctl_load_n}), .dout(sync_out));

  vatt_cmd_shifter #(.ID_W(ID_W), .CODE_W(CODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sync_out[2]), .sdat_s(sync_out[1]), .sld_n_s(sync_out[0]),
    .dev_id(dev_id), .staged_code(staged_code));

  assign frame_gain = gain_of(staged_code);
  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      vatt_gain_apply #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_apply (
        .clk(clk), .rst_n(rst_n), .strobe(sample_strobe),
        .gain(frame_gain), .din(ch_in[c]), .dout(ch_out[c]));
    end
  endgenerate

  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  AST_CHANNELS_SHARE_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && left_in == right_in) |=> (left_out == right_out)); // R8
endmodule

// File: tb/serial_vol_atten_test.sv
module serial_vol_atten_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b1, ctl_data = 1'b0, ctl_load_n = 1'b1;
  logic [7:0] dev_id = 8'h3C;
  logic sample_strobe = 1'b0;
  logic signed [15:0] left_in = '0, right_in = '0;
  logic signed [15:0] left_out, right_out;

  int checks = 0, errors = 0;
  int model_code = 0;

  always #4 clk = ~clk;

  serial_vol_atten uut (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_data(ctl_data),
    .ctl_load_n(ctl_load_n), .dev_id(dev_id), .sample_strobe(sample_strobe),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out));

  function automatic int exp_gain(input int code);
    return (code == 0) ? 65535 : (63 - code) * 1024;
  endfunction

  function automatic int exp_scale(input int x, input int g);
    longint p, r;
    p = longint'(x) * g + 32768;
    if (p >= 0) r = p / 65536;
    else        r = -((-p + 65535) / 65536);
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ctl_data = w[i];
      ctl_clk = 1'b0; wait_clks(4);
      ctl_clk = 1'b1; wait_clks(4);
    end
  endtask

  task automatic pulse_load();
    ctl_load_n = 1'b0; wait_clks(8);
    ctl_load_n = 1'b1; wait_clks(4);
  endtask

  task automatic send_cmd(input int id, input int code);
    shift_bits({18'd0, 6'(code), 8'(id)}, 14);
    pulse_load();
    if (8'(id) == dev_id) model_code = code;
  endtask

  task automatic frame(input string req, input int l, input int r);
    @(negedge clk);
    left_in = 16'(l); right_in = 16'(r); sample_strobe = 1'b1;
    @(negedge clk);
    sample_strobe = 1'b0;
    check(req, int'(left_out),  exp_scale(l, exp_gain(model_code)));
    check(req, int'(right_out), exp_scale(r, exp_gain(model_code)));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_clks(3);
    check("R4 reset left", int'(left_out), 0);
    check("R4 reset right", int'(right_out), 0);
    rst_n = 1'b1;
    wait_clks(3);
    frame("R4 zero dB after reset", 12000, -12000);
    frame("R6 negative full scale at 0 dB", -32768, 32767);

    send_cmd(8'h3C, 1);  frame("R5 code1", 30000, -30000);
    send_cmd(8'h3C, 31); frame("R5 code31", 30001, -1);
    send_cmd(8'h3C, 32); frame("R5 code32", -7, 7);
    send_cmd(8'h3C, 47); frame("R5 code47", 1, -2);
    send_cmd(8'h3C, 62); frame("R5 code62", 32767, -32768);
    send_cmd(8'h3C, 63); frame("R5 mute", 32767, -32768);
    check("R5 mute left zero", int'(left_out), 0);

    send_cmd(8'h3C, 10);
    send_cmd(8'hC3, 50);
    frame("R2 mismatched id ignored", 20000, 20000);

    shift_bits(32'h7, 3);
    send_cmd(8'h3C, 20);
    frame("R9 surplus leading bits", 25000, -25000);

    ctl_load_n = 1'b0; wait_clks(8);
    shift_bits({18'd0, 6'd5, 8'h3C}, 14);
    ctl_load_n = 1'b1; wait_clks(4);
    frame("R3 edges during low strobe ignored", 16384, -16384);

    send_cmd(8'h3C, 40);
    check("R7 output waits for frame", int'(left_out),
          exp_scale(16384, exp_gain(20)));
    @(negedge clk); left_in = 16'sd999; right_in = -16'sd999; wait_clks(2);
    check("R7 hold between frames", int'(right_out),
          exp_scale(-16384, exp_gain(20)));
    frame("R7 new gain at next frame", 16384, -16384);

    frame("R8 equal inputs equal outputs", -12345, -12345);
    check("R8 channels match", int'(left_out), int'(right_out));

    for (int n = 0; n < 60; n++) begin
      int id, code, l, r;
      id   = ($urandom % 4 == 0) ? int'($urandom % 256) : 8'h3C;
      code = int'($urandom % 64);
      l    = int'($signed(16'($urandom)));
      r    = int'($signed(16'($urandom)));
      send_cmd(id, code);
      frame("R1 random command and frame", l, r);
    end

    rst_n = 1'b0; wait_clks(2); rst_n = 1'b1; model_code = 0; wait_clks(3);
    frame("R4 reset restores 0 dB", 22222, -22222);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule